// File: doc/BRIEF.md
# Subroutine and Trap Next-PC Unit

This block chooses the next program counter for a 16-bit processor when it executes a subroutine call, a register jump or a system-call trap. It also produces the link write that stores the return address. Its inputs are the instruction word, the program counter after the fetch increment, a value read from the register file, and a word returned from memory. The register file and memory are outside the block. The block sends the register file the index of the base register it needs. It sends the link write to register 7.

A subroutine call either adds a signed 11-bit displacement to the incremented PC or jumps to the contents of a base register, depending on the mode bit. A register jump moves to a base register and does not link. A jump through register 7 is the return instruction. A trap links, then reads one word from a 256-entry vector table at the bottom of memory and jumps there. The trap takes two cycles. In the first cycle `busy` tells the fetch stage that `nextPc` is not valid yet. In the second cycle the returned word becomes the next PC. Every other instruction passes the incremented PC through.

Top module: `xfer_pc_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the block is idle. With `issue` low it drives `busy`=0, `linkWe`=0, `memRd`=0 and `nextPc`=`pcInc`. Asserting reset while a trap is pending cancels the trap.
- R2: When `issue` is low, or the opcode `ir[15:12]` is not 0100, 1100 or 1111, `nextPc` equals `pcInc`. `linkWe`, `memRd` and `busy` stay 0.
- R3: For opcode 0100 with `ir[11]`=1, `nextPc` = `pcInc` + sign-extended `ir[10:0]`, modulo 2^16, in the same cycle.
- R4: For opcode 0100 with `ir[11]`=0, `nextPc` = `baseVal` in the same cycle. For every instruction, `baseAddr` equals `ir[8:6]`.
- R5: Opcode 0100 in either mode asserts `linkWe` for one cycle, with `linkAddr`=7 and `linkData`=`pcInc`.
- R6: For a register-mode call whose base is register 7, `nextPc` is the `baseVal` presented in that cycle, which is the value before the link write. The link write still happens.
- R7: Opcode 1100 sets `nextPc` = `baseVal` and does not link. This includes base 7, the return instruction.
- R8: In the first trap cycle (opcode 1111), the block asserts `memRd` with `memAddr` = {8'h00, `ir[7:0]`}. It asserts `linkWe` with `linkData`=`pcInc`, and it asserts `busy`. `memRd` is never asserted without `busy`.
- R9: In the second trap cycle, `nextPc` = `memData`. `busy`, `linkWe` and `memRd` are 0, and `issue` and `ir` are ignored.
- R10: `busy` never stays high for two cycles in a row. The instruction after a trap is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | An instruction in `ir` is executed this cycle |
| ir | input | 16 | Instruction word |
| pcInc | input | 16 | Program counter after the fetch increment |
| baseVal | input | 16 | Register-file value of the register named by `baseAddr` |
| memData | input | 16 | Vector-table word, valid the cycle after `memRd` |
| nextPc | output | 16 | Next program counter, valid when `busy` is 0 |
| baseAddr | output | 3 | Base register index for the register-file read |
| linkWe | output | 1 | Write `linkData` to register `linkAddr` |
| linkAddr | output | 3 | Link register index, always 7 |
| linkData | output | 16 | Return address |
| memRd | output | 1 | Vector-table read request |
| memAddr | output | 16 | Vector-table address |
| busy | output | 1 | Trap in progress; `nextPc` not yet valid |

## Verification
The assertions assume three things about the inputs:
- `baseVal` is a combinational read of the register named by `baseAddr` in the same cycle.
- A register write takes effect at the clock edge.
- Memory returns the table word exactly one cycle after `memRd`.

The bench drives `baseVal` directly as the register value and places the table word on `memData` in the cycle after the request. In that second cycle it deliberately puts a different instruction on `ir` with `issue` high, so the inputs can change without breaking the trap sequence.

// File: rtl/xfer_pc_pkg.sv
package xfer_pc_pkg;

  // Source selected for the next program counter
  typedef enum logic [1:0] {
    PC_SEL_INC,
    PC_SEL_REL,
    PC_SEL_BASE,
    PC_SEL_TABLE
  } pcSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    pcSel_e pcSel;
    logic   linkWe;
    logic   tableRd;
    logic   busy;
  } xferStrobe_t;

  localparam int OPC_W = 4;
  localparam logic [OPC_W-1:0] OP_CALL = 4'b0100;
  localparam logic [OPC_W-1:0] OP_JUMP = 4'b1100;
  localparam logic [OPC_W-1:0] OP_TRAP = 4'b1111;

endpackage

// File: rtl/xfer_pc_ctl.sv
module xfer_pc_ctl
  import xfer_pc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             issue,
  input  logic [OPC_W-1:0] opcode,
  input  logic             relMode,
  output xferStrobe_t      strobe
);

  typedef enum logic {ST_IDLE, ST_VECTOR} ctlState_e;

  ctlState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe = '{pcSel: PC_SEL_INC, linkWe: 1'b0, tableRd: 1'b0, busy: 1'b0};
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (issue) begin
          case (opcode)
            OP_CALL: begin
              strobe.pcSel  = relMode ? PC_SEL_REL : PC_SEL_BASE;
              strobe.linkWe = 1'b1;
            end
            OP_JUMP: strobe.pcSel = PC_SEL_BASE;
            OP_TRAP: begin
              strobe.linkWe  = 1'b1;
              strobe.tableRd = 1'b1;
              strobe.busy    = 1'b1;
              stateD         = ST_VECTOR;
            end
            default: strobe.pcSel = PC_SEL_INC;
          endcase
        end
      end
      ST_VECTOR: begin
        // table word arrives now; new instructions wait
        strobe.pcSel = PC_SEL_TABLE;
        stateD       = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/xfer_pc_dp.sv
module xfer_pc_dp
  import xfer_pc_pkg::*;
#(
  parameter int XLEN      = 16,
  parameter int REL_W     = 11,
  parameter int VEC_W     = 8,
  parameter int RA_W      = 3,
  parameter int BASE_LSB  = 6,
  parameter int LINK_IDX  = 7
) (
  input  xferStrobe_t      strobe,
  input  logic [REL_W-1:0] ofsField,
  input  logic [XLEN-1:0]  pcInc,
  input  logic [XLEN-1:0]  baseVal,
  input  logic [XLEN-1:0]  memData,
  output logic [XLEN-1:0]  nextPc,
  output logic [XLEN-1:0]  linkData,
  output logic [RA_W-1:0]  linkAddr,
  output logic [RA_W-1:0]  baseAddr,
  output logic [XLEN-1:0]  memAddr
);

  localparam int SEXT_W = XLEN - REL_W;
  localparam int ZEXT_W = XLEN - VEC_W;

  logic [XLEN-1:0] relOfs;
  logic [XLEN-1:0] relTarget;

  assign relOfs    = {{SEXT_W{ofsField[REL_W-1]}}, ofsField};
  assign relTarget = pcInc + relOfs;
  assign memAddr   = {{ZEXT_W{1'b0}}, ofsField[VEC_W-1:0]};
  assign baseAddr  = ofsField[BASE_LSB +: RA_W];
  assign linkAddr  = RA_W'(LINK_IDX);
  assign linkData  = pcInc;

  always_comb begin
    case (strobe.pcSel)
      PC_SEL_REL:   nextPc = relTarget;
      PC_SEL_BASE:  nextPc = baseVal;
      PC_SEL_TABLE: nextPc = memData;
      default:      nextPc = pcInc;
    endcase
  end

endmodule

// File: rtl/xfer_pc_unit.sv
module xfer_pc_unit
  import xfer_pc_pkg::*;
#(
  parameter int XLEN     = 16,
  parameter int REL_W    = 11,
  parameter int VEC_W    = 8,
  parameter int RA_W     = 3,
  parameter int BASE_LSB = 6,
  parameter int LINK_IDX = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            issue,
  input  logic [XLEN-1:0] ir,
  input  logic [XLEN-1:0] pcInc,
  input  logic [XLEN-1:0] baseVal,
  input  logic [XLEN-1:0] memData,
  output logic [XLEN-1:0] nextPc,
  output logic [RA_W-1:0] baseAddr,
  output logic            linkWe,
  output logic [RA_W-1:0] linkAddr,
  output logic [XLEN-1:0] linkData,
  output logic            memRd,
  output logic [XLEN-1:0] memAddr,
  output logic            busy
);

  xferStrobe_t strobe;

  xfer_pc_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .issue   (issue),
    .opcode  (ir[XLEN-1 -: OPC_W]),
    .relMode (ir[REL_W]),
    .strobe  (strobe)
  );

  xfer_pc_dp #(
    .XLEN(XLEN), .REL_W(REL_W), .VEC_W(VEC_W),
    .RA_W(RA_W), .BASE_LSB(BASE_LSB), .LINK_IDX(LINK_IDX)
  ) u_dp (
    .strobe   (strobe),
    .ofsField (ir[REL_W-1:0]),
    .pcInc    (pcInc),
    .baseVal  (baseVal),
    .memData  (memData),
    .nextPc   (nextPc),
    .linkData (linkData),
    .linkAddr (linkAddr),
    .baseAddr (baseAddr),
    .memAddr  (memAddr)
  );

  assign linkWe = strobe.linkWe;
  assign memRd  = strobe.tableRd;
  assign busy   = strobe.busy;

endmodule

// File: rtl/xfer_pc_chk.sv
module xfer_pc_chk #(
  parameter int XLEN     = 16,
  parameter int REL_W    = 11,
  parameter int VEC_W    = 8,
  parameter int RA_W     = 3,
  parameter int BASE_LSB = 6,
  parameter int LINK_IDX = 7
) (
  input logic            clk,
  input logic            rstN,
  input logic            issue,
  input logic [XLEN-1:0] ir,
  input logic [XLEN-1:0] pcInc,
  input logic [XLEN-1:0] baseVal,
  input logic [XLEN-1:0] memData,
  input logic [XLEN-1:0] nextPc,
  input logic [RA_W-1:0] baseAddr,
  input logic            linkWe,
  input logic [RA_W-1:0] linkAddr,
  input logic [XLEN-1:0] linkData,
  input logic            memRd,
  input logic [XLEN-1:0] memAddr,
  input logic            busy
);

  logic            pendQ;
  logic [XLEN-1:0] relExp;
  logic            isCall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= busy;
  end

  assign relExp = pcInc + {{(XLEN-REL_W){ir[REL_W-1]}}, ir[REL_W-1:0]};
  assign isCall = issue && !pendQ && (ir[XLEN-1 -: 4] == 4'b0100);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!issue && !pendQ) |-> (nextPc == pcInc && !linkWe && !memRd && !busy));

  p_call_rel_r3: assert property (@(posedge clk) disable iff (!rstN)
    (isCall && ir[REL_W]) |-> (nextPc == relExp));

  p_call_base_r4: assert property (@(posedge clk) disable iff (!rstN)
    (isCall && !ir[REL_W]) |-> (nextPc == baseVal));

  p_base_index_r4: assert property (@(posedge clk) disable iff (!rstN)
    baseAddr == ir[BASE_LSB +: RA_W]);

  p_link_target_r5: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |-> (linkAddr == RA_W'(LINK_IDX) && linkData == pcInc));

  p_trap_request_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (memRd && linkWe && memAddr == {{(XLEN-VEC_W){1'b0}}, ir[VEC_W-1:0]}));

  p_read_needs_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> busy);

  p_trap_vector_r9: assert property (@(posedge clk) disable iff (!rstN)
    pendQ |-> (nextPc == memData && !linkWe && !memRd && !busy));

  p_busy_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

endmodule

bind xfer_pc_unit xfer_pc_chk #(
  .XLEN(XLEN), .REL_W(REL_W), .VEC_W(VEC_W),
  .RA_W(RA_W), .BASE_LSB(BASE_LSB), .LINK_IDX(LINK_IDX)
) u_chk (
  .clk(clk), .rstN(rstN), .issue(issue), .ir(ir), .pcInc(pcInc),
  .baseVal(baseVal), .memData(memData), .nextPc(nextPc),
  .baseAddr(baseAddr), .linkWe(linkWe), .linkAddr(linkAddr),
  .linkData(linkData), .memRd(memRd), .memAddr(memAddr), .busy(busy)
);

// File: tb/xfer_pc_unit_test.sv
module xfer_pc_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issue = 1'b0;
  logic [15:0] ir = 16'h0000, pcInc = 16'h0000, baseVal = 16'h0000, memData = 16'h0000;
  logic [15:0] nextPc, linkData, memAddr;
  logic [2:0]  baseAddr, linkAddr;
  logic        linkWe, memRd, busy;

  int nChecks = 0;
  int nFail   = 0;

  always #5 clk = ~clk;

  xfer_pc_unit uut (
    .clk(clk), .rstN(rstN), .issue(issue), .ir(ir), .pcInc(pcInc),
    .baseVal(baseVal), .memData(memData), .nextPc(nextPc),
    .baseAddr(baseAddr), .linkWe(linkWe), .linkAddr(linkAddr),
    .linkData(linkData), .memRd(memRd), .memAddr(memAddr), .busy(busy)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  // {ir, pcInc, baseVal, expected nextPc}, link expected, requirement
  localparam int NV = 12;
  localparam logic [63:0] VEC [NV] = '{
    {16'h4805, 16'h3001, 16'h0000, 16'h3006},  // R3 +5
    {16'h4FFF, 16'h3001, 16'h0000, 16'h3000},  // R3 -1
    {16'h4BFF, 16'h3000, 16'h0000, 16'h33FF},  // R3 +1023
    {16'h4C00, 16'h3000, 16'h0000, 16'h2C00},  // R3 -1024
    {16'h4805, 16'hFFFE, 16'h0000, 16'h0003},  // R3 wrap
    {16'h40C0, 16'h3001, 16'h1234, 16'h1234},  // R4 base 3
    {16'h41C0, 16'h3001, 16'hABCD, 16'hABCD},  // R6 base 7
    {16'h41FF, 16'h2000, 16'h0F0F, 16'h0F0F},  // R6 low bits set
    {16'hC080, 16'h3001, 16'h5555, 16'h5555},  // R7 base 2
    {16'hC1C0, 16'h3100, 16'h3050, 16'h3050},  // R7 return
    {16'h1261, 16'h3002, 16'h7777, 16'h3002},  // R2 add
    {16'h6000, 16'h3003, 16'h7777, 16'h3003}   // R2 load
  };
  localparam logic VLINK [NV] = '{1,1,1,1,1,1,1,1,0,0,0,0};
  localparam string VTAG [NV] = '{"R3","R3","R3","R3","R3","R4","R6","R6","R7","R7","R2","R2"};

  initial begin
    #(200000 * 10);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R1: quiet during reset
    ir = 16'h4805; pcInc = 16'h1111;
    #2;
    chk("R1 reset nextPc", nextPc, 16'h1111);
    chk("R1 reset linkWe", {15'h0, linkWe}, 16'h0);
    chk("R1 reset busy", {15'h0, busy}, 16'h0);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R1 after reset memRd", {15'h0, memRd}, 16'h0);
    chk("R1 after reset nextPc", nextPc, 16'h1111);

    // R2: call opcode without issue has no effect
    @(negedge clk); issue = 1'b0; ir = 16'h4805; pcInc = 16'h2222;
    #1;
    chk("R2 no issue nextPc", nextPc, 16'h2222);
    chk("R2 no issue linkWe", {15'h0, linkWe}, 16'h0);

    // single-cycle vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      issue = 1'b1; ir = VEC[i][63:48]; pcInc = VEC[i][47:32]; baseVal = VEC[i][31:16];
      #1;
      chk({VTAG[i], " nextPc"}, nextPc, VEC[i][15:0]);
      chk("R5 linkWe", {15'h0, linkWe}, {15'h0, VLINK[i]});
      if (VLINK[i]) begin
        chk("R5 linkAddr", {13'h0, linkAddr}, 16'h0007);
        chk("R5 linkData", linkData, VEC[i][47:32]);
      end
      chk("R4 baseAddr", {13'h0, baseAddr}, {13'h0, VEC[i][56:54]});
      chk("R2 memRd idle", {15'h0, memRd}, 16'h0);
      chk("R10 busy idle", {15'h0, busy}, 16'h0);
    end

    // R8: trap first cycle
    @(negedge clk); issue = 1'b1; ir = 16'hF021; pcInc = 16'h3010;
    #1;
    chk("R8 memRd", {15'h0, memRd}, 16'h1);
    chk("R8 memAddr", memAddr, 16'h0021);
    chk("R8 busy", {15'h0, busy}, 16'h1);
    chk("R8 linkWe", {15'h0, linkWe}, 16'h1);
    chk("R8 linkData", linkData, 16'h3010);
    // R9: vector word returned; new call on ir ignored
    @(negedge clk); memData = 16'h0420; ir = 16'h4805; pcInc = 16'h3011;
    #1;
    chk("R9 nextPc", nextPc, 16'h0420);
    chk("R9 linkWe", {15'h0, linkWe}, 16'h0);
    chk("R9 memRd", {15'h0, memRd}, 16'h0);
    chk("R9 busy", {15'h0, busy}, 16'h0);
    // R10: same call now handled
    @(negedge clk);
    #1;
    chk("R10 nextPc", nextPc, 16'h3016);
    chk("R10 linkWe", {15'h0, linkWe}, 16'h1);

    // R8: top table entry
    @(negedge clk); ir = 16'hF0FF; pcInc = 16'h4000;
    #1;
    chk("R8 memAddr top", memAddr, 16'h00FF);
    @(negedge clk); memData = 16'hBEEF; issue = 1'b0;
    #1;
    chk("R9 nextPc top", nextPc, 16'hBEEF);

    // R1: reset cancels a pending trap
    @(negedge clk); issue = 1'b1; ir = 16'hF025; pcInc = 16'h5000;
    #1; rstN = 1'b0;
    @(negedge clk); rstN = 1'b1; ir = 16'h1261; pcInc = 16'h4000; memData = 16'hDEAD;
    #1;
    chk("R1 cancel nextPc", nextPc, 16'h4000);
    chk("R1 cancel busy", {15'h0, busy}, 16'h0);

    @(negedge clk); issue = 1'b0;
    summary();
  end

endmodule